// File: doc/BRIEF.md
# Debug Control and Status Register Block

This block holds the register state of an on-chip debug unit that an external debug tool reaches through a plain register-access port. It has two 32-bit registers. The control register carries an external-debug enable bit, and its other bits are guarded by that enable. The status register collects debug events: hardware inputs set its bits, and the tool clears a bit by writing a one to it.

The block also tracks the debug state of the CPU. It records whether the CPU is halted in debug mode and whether the CPU status/control scan register has been refreshed since that mode was entered. The tool asks to leave debug mode or to execute one step. The block grants that request only when the scan register is fresh. Otherwise it refuses the request with a one-cycle error pulse.

All pins are plain control and status signals. There is no streaming path, so no valid/ready handshake is used. A register write completes in the cycle in which `reg_wr` is sampled high, and reads are combinational.

Top module: `dbgreg_top`

## Requirements
- R1: While the enable (control bit 31, LSB-numbered) is 0 before a control write, that write updates only bit 31; bits 30..0 keep their values.
- R2: While the enable is already 1 before a control write, all 32 control bits take the written value, including a 0 written to the enable.
- R3: Writing the status register clears every bit that is written as one and leaves the bits written as zero unchanged.
- R4: When an event input sets a status bit in the same cycle that a write-one clears it, the bit ends up set.
- R5: Status positions are numbered from the MSB (position p is vector bit 31-p). Implemented positions are 0..16, 21..26 and 31, which gives the mask 0xFFFF87E1. Every other bit always reads 0, whatever the events or writes.
- R6: After reset the control register is 0 and the status register is 0x10000000 (MSB position 3 set). `in_debug`, `scan_fresh`, `exit_ok`, `step_ok` and `req_err` are all 0.
- R7: `dbg_enter` sets `in_debug` and clears `scan_fresh`. `scan_upd` sets `scan_fresh`. If both occur in the same cycle, `dbg_enter` wins.
- R8: An exit request made while in debug with `scan_fresh` set gives a one-cycle `exit_ok` pulse on the next cycle and clears `in_debug`.
- R9: A step request made while in debug with `scan_fresh` set gives a one-cycle `step_ok` pulse. `in_debug` stays set and `scan_fresh` is cleared.
- R10: Any other exit or step request gives a one-cycle `req_err` pulse and leaves `in_debug` and `scan_fresh` unchanged. This includes simultaneous exit and step requests.
- R11: `reg_rdata` shows the status register when `reg_sel` is 1 and the control register when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects control, 1 selects status |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |
| evt_set | input | 32 | Per-bit event set pulses for status |
| dbg_enter | input | 1 | CPU has entered debug mode |
| scan_upd | input | 1 | Scan register update strobe |
| exit_req | input | 1 | Request to leave debug mode |
| step_req | input | 1 | Request for a single step |
| in_debug | output | 1 | CPU is in debug mode |
| scan_fresh | output | 1 | Scan register refreshed since entry or last step |
| ext_dbg_en | output | 1 | External-debug enable bit |
| exit_ok | output | 1 | Exit granted pulse |
| step_ok | output | 1 | Step granted pulse |
| req_err | output | 1 | Request refused pulse |

## Verification
Two pairs of actions can land in the same cycle. The first pair is an event set and a write-one clear on the same status bit. The second pair is `dbg_enter` and `scan_upd`. The bench drives both members of each pair in one cycle. It then judges the outcome at the ports: the status bit must read back set, and a following exit request must be refused because `scan_fresh` stayed low.

// File: rtl/dbgreg_pkg.sv
package dbgreg_pkg;
  localparam int REG_W = 32;
  localparam int MRR_POS = 3;

  function automatic logic [REG_W-1:0] stat_impl_mask();
    logic [REG_W-1:0] m;
    m = '0;
    for (int p = 0; p < REG_W; p++) begin
      if (p <= 16 || (p >= 21 && p <= 26) || p == 31) m[REG_W-1-p] = 1'b1;
    end
    return m;
  endfunction

  function automatic logic [REG_W-1:0] stat_reset_val();
    logic [REG_W-1:0] v;
    v = '0;
    v[REG_W-1-MRR_POS] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/dbgreg_ctrl.sv
module dbgreg_ctrl
  import dbgreg_pkg::*;
#(
  parameter int EN_IDX = 31
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] ctrl_q
);
  localparam logic [REG_W-1:0] EN_MASK = {{(REG_W-1){1'b0}}, 1'b1} << EN_IDX;

  always_ff @(posedge clk) begin
    if (!rst_n) ctrl_q <= '0;
    else if (wr) begin
      if (ctrl_q[EN_IDX]) ctrl_q <= wdata;
      else ctrl_q <= (ctrl_q & ~EN_MASK) | (wdata & EN_MASK);
    end
  end

  p_locked_bits_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !ctrl_q[EN_IDX]) |=> ((ctrl_q & ~EN_MASK) == ($past(ctrl_q) & ~EN_MASK)));
  p_open_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && ctrl_q[EN_IDX]) |=> (ctrl_q == $past(wdata)));
endmodule

// File: rtl/dbgreg_stat.sv
module dbgreg_stat
  import dbgreg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  input  logic [REG_W-1:0] evt,
  output logic [REG_W-1:0] stat_q
);
  localparam logic [REG_W-1:0] IMPL = stat_impl_mask();
  localparam logic [REG_W-1:0] RST = stat_reset_val();

  logic [REG_W-1:0] clr;
  assign clr = wr ? wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) stat_q <= RST;
    else stat_q <= ((stat_q & ~clr) | evt) & IMPL;
  end

  p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & $past(evt & IMPL)) == $past(evt & IMPL)));
  p_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && evt == '0) |=> ((stat_q & $past(wdata)) == '0));
  p_unimpl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((stat_q & ~IMPL) == '0));
endmodule

// File: rtl/dbgreg_gate.sv
module dbgreg_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic dbg_enter,
  input  logic scan_upd,
  input  logic exit_req,
  input  logic step_req,
  output logic in_debug,
  output logic scan_fresh,
  output logic exit_ok,
  output logic step_ok,
  output logic req_err
);
  logic ready, do_exit, do_step, any_req;
  assign ready   = in_debug && scan_fresh;
  assign do_exit = exit_req && !step_req && ready;
  assign do_step = step_req && !exit_req && ready;
  assign any_req = exit_req || step_req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_debug   <= 1'b0;
      scan_fresh <= 1'b0;
      exit_ok    <= 1'b0;
      step_ok    <= 1'b0;
      req_err    <= 1'b0;
    end else begin
      exit_ok <= do_exit;
      step_ok <= do_step;
      req_err <= any_req && !do_exit && !do_step;
      if (dbg_enter) begin
        in_debug   <= 1'b1;
        scan_fresh <= 1'b0;
      end else if (do_exit) begin
        in_debug   <= 1'b0;
        scan_fresh <= 1'b0;
      end else if (do_step) begin
        scan_fresh <= 1'b0;
      end else if (scan_upd) begin
        scan_fresh <= 1'b1;
      end
    end
  end

  p_exit_needs_fresh_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(exit_ok) |-> ($past(in_debug) && $past(scan_fresh)));
  p_step_stays_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (step_ok && !$past(dbg_enter)) |-> (in_debug && !scan_fresh));
  p_refuse_keeps_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_err && !$past(dbg_enter) && !$past(scan_upd)) |-> ($stable(in_debug) && $stable(scan_fresh)));
  p_outcome_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({exit_ok, step_ok, req_err}));
  p_enter_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_enter |=> (in_debug && !scan_fresh));
endmodule

// File: rtl/dbgreg_top.sv
module dbgreg_top
  import dbgreg_pkg::*;
#(
  parameter int EN_IDX = 31
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_sel,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic [REG_W-1:0] evt_set,
  input  logic             dbg_enter,
  input  logic             scan_upd,
  input  logic             exit_req,
  input  logic             step_req,
  output logic             in_debug,
  output logic             scan_fresh,
  output logic             ext_dbg_en,
  output logic             exit_ok,
  output logic             step_ok,
  output logic             req_err
);
  logic [REG_W-1:0] ctrl_q, stat_q;

  dbgreg_ctrl #(.EN_IDX(EN_IDX)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr && !reg_sel),
    .wdata(reg_wdata), .ctrl_q(ctrl_q)
  );

  dbgreg_stat u_stat (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr && reg_sel),
    .wdata(reg_wdata), .evt(evt_set), .stat_q(stat_q)
  );

  dbgreg_gate u_gate (
    .clk(clk), .rst_n(rst_n), .dbg_enter(dbg_enter), .scan_upd(scan_upd),
    .exit_req(exit_req), .step_req(step_req), .in_debug(in_debug),
    .scan_fresh(scan_fresh), .exit_ok(exit_ok), .step_ok(step_ok),
    .req_err(req_err)
  );

  assign reg_rdata  = reg_sel ? stat_q : ctrl_q;
  assign ext_dbg_en = ctrl_q[EN_IDX];
endmodule

// File: tb/dbgreg_top_test.sv
module dbgreg_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0, evt_set = '0;
  logic [31:0] reg_rdata;
  logic        dbg_enter = 1'b0, scan_upd = 1'b0, exit_req = 1'b0, step_req = 1'b0;
  logic        in_debug, scan_fresh, ext_dbg_en, exit_ok, step_ok, req_err;
  int          checks = 0, failures = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  dbgreg_top uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_set(evt_set),
    .dbg_enter(dbg_enter), .scan_upd(scan_upd), .exit_req(exit_req),
    .step_req(step_req), .in_debug(in_debug), .scan_fresh(scan_fresh),
    .ext_dbg_en(ext_dbg_en), .exit_ok(exit_ok), .step_ok(step_ok),
    .req_err(req_err)
  );

  // fields: wr, sel, wdata, evt, expected readback
  localparam int NV = 10;
  localparam logic [97:0] VEC [NV] = '{
    {1'b1, 1'b0, 32'hFFFFFFFF, 32'h0, 32'h80000000},  // R1
    {1'b1, 1'b0, 32'h000000A5, 32'h0, 32'h000000A5},  // R2
    {1'b1, 1'b0, 32'hFFFFFFFF, 32'h0, 32'h800000A5},  // R1
    {1'b1, 1'b0, 32'h80001234, 32'h0, 32'h80001234},  // R2
    {1'b1, 1'b1, 32'h00000000, 32'hFFFFFFFF, 32'hFFFF87E1}, // R5
    {1'b1, 1'b1, 32'hFFFFFFFF, 32'h0, 32'h00000000},  // R3
    {1'b0, 1'b1, 32'h00000000, 32'h00000021, 32'h00000021}, // R5
    {1'b1, 1'b1, 32'h00000001, 32'h00000001, 32'h00000021}, // R4
    {1'b1, 1'b1, 32'h00000020, 32'h0, 32'h00000001},  // R3
    {1'b1, 1'b1, 32'hFFFFFFFF, 32'h80000000, 32'h80000000}  // R4
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  initial begin
    #400000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    reg_sel = 1'b0;
    chk("R6 ctrl", reg_rdata, 32'h0);
    reg_sel = 1'b1; #0.1;
    chk("R6 stat", reg_rdata, 32'h10000000);
    chk("R6 flags", {26'h0, in_debug, scan_fresh, ext_dbg_en, exit_ok, step_ok, req_err}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      reg_wr = VEC[i][97]; reg_sel = VEC[i][96];
      reg_wdata = VEC[i][95:64]; evt_set = VEC[i][63:32];
      tick();
      reg_wr = 1'b0; evt_set = '0; #0.1;
      chk($sformatf("R11 vec%0d", i), reg_rdata, VEC[i][31:0]);
    end
    reg_sel = 1'b0; #0.1;
    chk("R1 ext_dbg_en", {31'h0, ext_dbg_en}, 32'h1);

    // R10: exit while not in debug
    exit_req = 1'b1; tick(); exit_req = 1'b0;
    chk("R10 err no debug", {29'h0, exit_ok, step_ok, req_err}, 32'h1);
    chk("R10 in_debug kept", {31'h0, in_debug}, 32'h0);
    tick();
    chk("R10 pulse width", {31'h0, req_err}, 32'h0);

    // R7: enter and update together, enter wins
    dbg_enter = 1'b1; scan_upd = 1'b1; tick(); dbg_enter = 1'b0; scan_upd = 1'b0;
    chk("R7 enter wins", {30'h0, in_debug, scan_fresh}, 32'h2);
    exit_req = 1'b1; tick(); exit_req = 1'b0;
    chk("R10 stale exit refused", {29'h0, exit_ok, step_ok, req_err}, 32'h1);
    chk("R10 stays in debug", {31'h0, in_debug}, 32'h1);

    scan_upd = 1'b1; tick(); scan_upd = 1'b0;
    chk("R7 update sets fresh", {31'h0, scan_fresh}, 32'h1);

    // R10: both requests
    exit_req = 1'b1; step_req = 1'b1; tick(); exit_req = 1'b0; step_req = 1'b0;
    chk("R10 both refused", {29'h0, exit_ok, step_ok, req_err}, 32'h1);
    chk("R10 state kept", {30'h0, in_debug, scan_fresh}, 32'h3);

    // R9: step
    step_req = 1'b1; tick(); step_req = 1'b0;
    chk("R9 step granted", {29'h0, exit_ok, step_ok, req_err}, 32'h2);
    chk("R9 state", {30'h0, in_debug, scan_fresh}, 32'h2);
    step_req = 1'b1; tick(); step_req = 1'b0;
    chk("R9 second step refused", {29'h0, exit_ok, step_ok, req_err}, 32'h1);

    // R8: exit
    scan_upd = 1'b1; tick(); scan_upd = 1'b0;
    exit_req = 1'b1; tick(); exit_req = 1'b0;
    chk("R8 exit granted", {29'h0, exit_ok, step_ok, req_err}, 32'h4);
    chk("R8 left debug", {31'h0, in_debug}, 32'h0);
    tick();
    chk("R8 pulse width", {31'h0, exit_ok}, 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule